// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

A purely combinational adder of parameterised width, built as a row of equal lookahead slices of four bits each by default (four slices, sixteen bits). Each slice forms bitwise generate (both operand bits high) and propagate (operand bits differ). It derives every internal carry from a flattened sum-of-products over those terms, so no carry waits on its neighbour. Each slice also reports a group propagate and a group generate.

A second lookahead unit of the same form takes the per-slice group pairs and the incoming carry. It produces the carry into every slice and the final carry out, so the slices never wait on one another. The group pair over the whole word is brought out so a wider adder can stack this block as one slice of a third level. A build-time switch chains the slice carries one after another instead, to compare the two structures. The results are identical in both modes.

Top module: `cla_adder_top`

## Requirements
- R1: `sum_o` equals the low DATA_W bits of `a_i + b_i + carry_i`, with DATA_W = SLICE_W * N_SLICES.
- R2: `carry_o` equals bit DATA_W of `a_i + b_i + carry_i`.
- R3: `grp_prop_o` is 1 exactly when every bit of `a_i ^ b_i` is 1. When it is 1, `carry_o` equals `carry_i`.
- R4: `grp_gen_o` is 1 exactly when `a_i + b_i` (without the carry-in) reaches 2**DATA_W, independent of `carry_i`.
- R5: An incoming carry crosses a fully propagating word: all-ones plus zero with carry-in 1 gives sum 0 and carry-out 1.
- R6: With `RIPPLE_SLICES` = 1, each slice takes its carry from the previous slice's carry-out. Sum, carry-out and group outputs match the lookahead build for every input.
- R7: All-ones plus one with carry-in 0 gives sum 0 and carry-out 1. 0x8000 plus 0x8000 gives sum 0 and carry-out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | DATA_W | Sum bits |
| carry_o | output | 1 | Carry out of the top bit |
| grp_prop_o | output | 1 | Whole-word group propagate |
| grp_gen_o | output | 1 | Whole-word group generate |

## Verification
The incoming carry and the operands can both decide the carry-out at the same time. A word-wide propagate passes the carry-in through, while a generate forces the carry-out regardless of it. Both are provoked in an exhaustive sweep of a narrow two-by-two-bit build, where every operand pair is applied with both carry-in values. Each result is judged against integer addition computed in the bench, and the lookahead and chained builds are compared on the same vectors. The full-width default is then driven with pseudo-random operands and the named corner words.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned CLA_SLICE_W_DEF = 4;
  localparam int unsigned CLA_SLICES_DEF  = 4;

  typedef struct packed {
    logic prop;
    logic gen;
  } grp_pair_t;
endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] p_i,
  input  logic [N-1:0] g_i,
  input  logic         c_i,
  output logic [N:1]   c_o,
  output logic         gp_o,
  output logic         gg_o
);
  // flat sum-of-products for the carry out of position top
  function automatic logic sop_carry(input logic [N-1:0] pv, input logic [N-1:0] gv,
                                     input logic cv, input int top);
    logic acc;
    logic prod;
    acc = cv;
    for (int k = 0; k <= top; k++) acc = acc & pv[k];
    for (int j = 0; j <= top; j++) begin
      prod = gv[j];
      for (int k = j + 1; k <= top; k++) prod = prod & pv[k];
      acc = acc | prod;
    end
    return acc;
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_carry
    assign c_o[i+1] = sop_carry(p_i, g_i, c_i, i);
  end

  assign gp_o = &p_i;
  assign gg_o = sop_carry(p_i, g_i, 1'b0, N - 1);

  always_comb begin
    if (gp_o) a_r3_prop_passes_cin : assert (c_o[N] == c_i);
    if (gg_o) a_r4_gen_forces_carry : assert (c_o[N]);
  end
endmodule

// File: rtl/cla_slice.sv
module cla_slice #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o,
  output logic         gp_o,
  output logic         gg_o
);
  logic [W-1:0] prop;
  logic [W-1:0] gen;
  logic [W:1]   carry;
  logic [W-1:0] carry_in_bits;

  assign prop = a_i ^ b_i;
  assign gen  = a_i & b_i;

  cla_lookahead #(.N(W)) u_la (
    .p_i (prop),
    .g_i (gen),
    .c_i (c_i),
    .c_o (carry),
    .gp_o(gp_o),
    .gg_o(gg_o)
  );

  if (W > 1) begin : g_wide
    assign carry_in_bits = {carry[W-1:1], c_i};
  end else begin : g_one
    assign carry_in_bits = c_i;
  end

  assign s_o = prop ^ carry_in_bits;
  assign c_o = carry[W];

  always_comb begin
    a_r1_slice_sum : assert ({c_o, s_o} == ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(c_i)));
  end
endmodule

// File: rtl/cla_adder_top.sv
module cla_adder_top
  import cla_pkg::*;
#(
  parameter int unsigned SLICE_W       = CLA_SLICE_W_DEF,
  parameter int unsigned N_SLICES      = CLA_SLICES_DEF,
  parameter bit          RIPPLE_SLICES = 1'b0,
  localparam int unsigned DATA_W       = SLICE_W * N_SLICES
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o,
  output logic              grp_prop_o,
  output logic              grp_gen_o
);
  grp_pair_t [N_SLICES-1:0] grp;
  logic [N_SLICES-1:0] grp_p;
  logic [N_SLICES-1:0] grp_g;
  logic [N_SLICES-1:0] slice_cin;
  logic [N_SLICES-1:0] slice_cout;
  logic [N_SLICES:1]   lvl2_carry;

  for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
    cla_slice #(.W(SLICE_W)) u_slice (
      .a_i (a_i[k*SLICE_W +: SLICE_W]),
      .b_i (b_i[k*SLICE_W +: SLICE_W]),
      .c_i (slice_cin[k]),
      .s_o (sum_o[k*SLICE_W +: SLICE_W]),
      .c_o (slice_cout[k]),
      .gp_o(grp[k].prop),
      .gg_o(grp[k].gen)
    );
    assign grp_p[k] = grp[k].prop;
    assign grp_g[k] = grp[k].gen;

    if (k == 0) begin : g_first
      assign slice_cin[k] = carry_i;
    end else if (RIPPLE_SLICES) begin : g_chain
      assign slice_cin[k] = slice_cout[k-1];
    end else begin : g_look
      assign slice_cin[k] = lvl2_carry[k];
    end
  end

  cla_lookahead #(.N(N_SLICES)) u_lvl2 (
    .p_i (grp_p),
    .g_i (grp_g),
    .c_i (carry_i),
    .c_o (lvl2_carry),
    .gp_o(grp_prop_o),
    .gg_o(grp_gen_o)
  );

  if (RIPPLE_SLICES) begin : g_cout_chain
    assign carry_o = slice_cout[N_SLICES-1];
  end else begin : g_cout_look
    assign carry_o = lvl2_carry[N_SLICES];
  end

  always_comb begin
    a_r1_word_sum : assert ({carry_o, sum_o} ==
                            ({1'b0, a_i} + {1'b0, b_i} + (DATA_W+1)'(carry_i)));
    if (grp_prop_o) a_r3_word_prop : assert (sum_o == {DATA_W{~carry_i}});
    if (grp_gen_o)  a_r4_word_gen  : assert (carry_o && !grp_prop_o);
    for (int k = 0; k < N_SLICES; k++) begin
      a_r6_chain_matches_lookahead : assert (slice_cout[k] == lvl2_carry[k+1]);
    end
  end
endmodule

// File: tb/sim_cla_adder_top.sv
module sim_cla_adder_top;
  localparam int W16 = 16;
  localparam int W4  = 4;

  logic clk;
  logic rst_n;
  int   n_checks;
  int   n_fail;
  bit   done;

  logic [W16-1:0] a16, b16;
  logic           c16;
  logic [W16-1:0] s_la, s_rp;
  logic           co_la, co_rp, gp_la, gp_rp, gg_la, gg_rp;

  logic [W4-1:0] a4, b4;
  logic          c4;
  logic [W4-1:0] s4_la, s4_rp;
  logic          co4_la, co4_rp, gp4_la, gp4_rp, gg4_la, gg4_rp;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  cla_adder_top u0 (.a_i(a16), .b_i(b16), .carry_i(c16), .sum_o(s_la),
    .carry_o(co_la), .grp_prop_o(gp_la), .grp_gen_o(gg_la));
  cla_adder_top #(.RIPPLE_SLICES(1'b1)) u1 (.a_i(a16), .b_i(b16), .carry_i(c16),
    .sum_o(s_rp), .carry_o(co_rp), .grp_prop_o(gp_rp), .grp_gen_o(gg_rp));
  cla_adder_top #(.SLICE_W(2), .N_SLICES(2)) u2 (.a_i(a4), .b_i(b4), .carry_i(c4),
    .sum_o(s4_la), .carry_o(co4_la), .grp_prop_o(gp4_la), .grp_gen_o(gg4_la));
  cla_adder_top #(.SLICE_W(2), .N_SLICES(2), .RIPPLE_SLICES(1'b1)) u3 (.a_i(a4),
    .b_i(b4), .carry_i(c4), .sum_o(s4_rp), .carry_o(co4_rp), .grp_prop_o(gp4_rp),
    .grp_gen_o(gg4_rp));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run16(input logic [15:0] a, input logic [15:0] b, input logic c);
    logic [16:0] tot;
    logic [16:0] raw;
    @(posedge clk);
    a16 = a; b16 = b; c16 = c;
    @(negedge clk);
    tot = {1'b0, a} + {1'b0, b} + 17'(c);
    raw = {1'b0, a} + {1'b0, b};
    chk(s_la == tot[15:0], "R1 sum", s_la, tot[15:0]);
    chk(co_la == tot[16], "R2 carry", co_la, tot[16]);
    chk(gp_la == ((a ^ b) == 16'hFFFF), "R3 gp", gp_la, (a ^ b) == 16'hFFFF);
    chk(gg_la == raw[16], "R4 gg", gg_la, raw[16]);
    chk({co_rp, s_rp, gp_rp, gg_rp} == {co_la, s_la, gp_la, gg_la}, "R6 chained16",
        {co_rp, s_rp, gp_rp, gg_rp}, {tot, (a ^ b) == 16'hFFFF, raw[16]});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr;
    logic [4:0]  t4;
    logic [4:0]  r4;
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    a16 = '0; b16 = '0; c16 = 1'b0; a4 = '0; b4 = '0; c4 = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 idle state with zero operands
    chk({co_la, s_la, gp_la, gg_la} == '0, "R1 idle", {co_la, s_la, gp_la, gg_la}, 0);

    // R1 R2 R3 R4 R6 exhaustive sweep of a 2x2-bit build
    for (int ai = 0; ai < 16; ai++) begin
      for (int bi = 0; bi < 16; bi++) begin
        for (int ci = 0; ci < 2; ci++) begin
          @(posedge clk);
          a4 = 4'(ai); b4 = 4'(bi); c4 = 1'(ci);
          @(negedge clk);
          t4 = 5'(ai + bi + ci);
          r4 = 5'(ai + bi);
          chk(s4_la == t4[3:0], "R1 small sum", s4_la, t4[3:0]);
          chk(co4_la == t4[4], "R2 small carry", co4_la, t4[4]);
          chk(gp4_la == ((ai ^ bi) == 15), "R3 small gp", gp4_la, (ai ^ bi) == 15);
          chk(gg4_la == r4[4], "R4 small gg", gg4_la, r4[4]);
          chk({co4_rp, s4_rp, gp4_rp, gg4_rp} == {co4_la, s4_la, gp4_la, gg4_la},
              "R6 chained small", {co4_rp, s4_rp, gp4_rp, gg4_rp},
              {co4_la, s4_la, gp4_la, gg4_la});
        end
      end
    end

    // R5 carry-in crossing an all-propagate word
    run16(16'hFFFF, 16'h0000, 1'b1);
    chk(s_la == 16'h0 && co_la, "R5 cin through", {co_la, s_la}, 17'h10000);
    run16(16'hAAAA, 16'h5555, 1'b0);
    chk(s_la == 16'hFFFF && !co_la && gp_la, "R3 propagate no cin", {co_la, s_la}, 17'h0FFFF);
    // R7 corner words
    run16(16'hFFFF, 16'h0001, 1'b0);
    chk(s_la == 16'h0 && co_la, "R7 ones plus one", {co_la, s_la}, 17'h10000);
    run16(16'h8000, 16'h8000, 1'b0);
    chk(s_la == 16'h0 && co_la && gg_la, "R7 top bits", {co_la, s_la}, 17'h10000);
    run16(16'hFFFF, 16'hFFFF, 1'b1);
    run16(16'h0FFF, 16'h0001, 1'b0);
    run16(16'h00FF, 16'h0F01, 1'b1);

    // R1 R2 R4 R6 pseudo-random operands
    lfsr = 16'hACE1;
    for (int n = 0; n < 1500; n++) begin
      logic [15:0] aa;
      logic [15:0] bb;
      aa = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bb = lfsr ^ {lfsr[7:0], lfsr[15:8]};
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run16(aa, bb, lfsr[0]);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule